// File: doc/BRIEF.md
# Indexed Bit-Operation Execution Unit

This unit carries out one instruction of the indexed bit-manipulation group of an 8-bit processor. The group covers eight rotate and shift operations, single-bit test, single-bit clear and single-bit set, all acting on one memory byte. The byte's address is a 16-bit index base plus a signed 8-bit offset. The surrounding core supplies:

- the index base,
- the offset byte,
- the final opcode byte,
- the current flag byte,

and pulses `start`. The unit then reads the byte, computes the result and the new flags, and writes the result back where the operation requires it. When the low opcode field names a register, it also copies the result into that register. It ends by raising `done` for one cycle, with the new flags, the memory-pointer value and the cycle cost of the instruction on its outputs.

Control is a five-state machine:

- **IDLE** goes to **READ** on `start`. The operands are latched, and the effective address is loaded into the memory-pointer register.
- **READ** drives the read strobe and always goes to **EXEC**.
- **EXEC** takes the memory byte, registers the result and flags, and goes to **FIN** for a bit test or to **WRITE** otherwise.
- **WRITE** drives the memory write strobe, and the register write where one applies, then goes to **FIN**.
- **FIN** raises `done` and the fetch-adjust pulse, then returns to **IDLE**.

The fetch-adjust pulse tells the core to take one from its refresh counter, because the last opcode byte of this group is not an opcode fetch.

Top module: `ixbit_unit`

## Requirements
- R1: The effective address equals `idx_base` plus `disp` read as a signed two's-complement byte, modulo 2^16. It is on `mem_addr` with `mem_rd` high in the first cycle after an accepted `start`. `mem_ptr` holds that address from then until the next accepted start.
- R2: Opcode bits 7:6 choose the class: 0 = rotate/shift, 1 = bit test, 2 = bit clear, 3 = bit set.
- R3: For rotate/shift, opcode bits 5:3 choose the operation, with the carry flag (flag bit 0) used as the carry input:
  - 0: rotate left circular
  - 1: rotate right circular
  - 2: rotate left through carry
  - 3: rotate right through carry
  - 4: arithmetic shift left
  - 5: arithmetic shift right (sign kept)
  - 6: shift left inserting 1
  - 7: logical shift right
- R4: Rotate/shift flags use the layout S=bit7, Z=bit6, Y=bit5, H=bit4, X=bit3, P/V=bit2, N=bit1, C=bit0. C gets the bit shifted out. S, Y and X copy result bits 7, 5 and 3. Z is set for a zero result. P/V is set for even parity of the result. H and N are cleared.
- R5: Bit clear and bit set clear or set the bit numbered by opcode bits 5:3, and `flags_out` equals `flags_in`.
- R6: Bit test makes no memory write and no register write. Its flags are:
  - Z and P/V are set when the tested bit is 0.
  - H is set and N is cleared.
  - S is set only when bit 7 is tested and is 1.
  - C is kept.
  - Y and X copy bits 5 and 3 of the effective address's high byte.
- R7: Every non-test operation writes its result to the effective address. When opcode bits 2:0 are not 6, it also pulses `reg_we` with `reg_sel` equal to those bits and `reg_wdata` equal to the result. The codes 0,1,2,3,4,5,7 stand for registers B,C,D,E,H,L,A. With code 6 there is no register write.
- R8: `cycles` reports 20 for a bit test and 23 for every other operation.
- R9: `mem_wr` rises two cycles after `mem_rd`, and the two strobes are never high together. `done` rises at the third clock edge after an accepted start for a bit test, and at the fourth for other operations, and lasts one cycle.
- R10: `fetch_adj` pulses exactly once per instruction, in the same cycle as `done`.
- R11: A `start` while `busy` is high is ignored, and changing the operand inputs after acceptance has no effect on the result.
- R12: After reset the outputs are: `busy`, `done`, `mem_rd`, `mem_wr`, `reg_we` and `fetch_adj` low, and `mem_ptr`, `cycles` and `flags_out` zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin one instruction when idle |
| idx_base | input | 16 | Index register value |
| disp | input | 8 | Signed offset byte |
| opcode | input | 8 | Final opcode byte of the group |
| flags_in | input | 8 | Current flag byte |
| busy | output | 1 | Instruction in progress |
| done | output | 1 | One-cycle completion pulse |
| mem_addr | output | 16 | Memory address |
| mem_rd | output | 1 | Memory read strobe, data returned next cycle |
| mem_wr | output | 1 | Memory write strobe |
| mem_wdata | output | 8 | Memory write data |
| mem_rdata | input | 8 | Memory read data |
| reg_we | output | 1 | Register-file write strobe |
| reg_sel | output | 3 | Register code (0..5,7 = B,C,D,E,H,L,A) |
| reg_wdata | output | 8 | Register write data |
| flags_out | output | 8 | New flag byte, valid with done |
| mem_ptr | output | 16 | Memory-pointer register |
| cycles | output | 5 | Reported cycle count |
| fetch_adj | output | 1 | Refresh-counter decrement pulse |

## Verification
The bench builds the unit with its defaults: a 16-bit address, 8-bit offset, and costs of 20 and 23. These defaults make all 256 opcodes reachable, and every opcode is run against eight data, base, offset and carry patterns. Two of the patterns wrap the address, one past the top of memory and one below zero, so sign extension and the modulo-2^16 sum are covered. The memory model is 256 bytes indexed by the low address byte, while the full 16-bit address is compared on each read. Each run also drives a second `start` with altered operands while the unit is busy.

// File: rtl/ixbit_pkg.sv
package ixbit_pkg;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_READ  = 3'd1,
        ST_EXEC  = 3'd2,
        ST_WRITE = 3'd3,
        ST_FIN   = 3'd4
    } state_t;

    typedef enum logic [1:0] {
        CL_SHIFT = 2'd0,
        CL_TEST  = 2'd1,
        CL_CLR   = 2'd2,
        CL_SET   = 2'd3
    } cls_t;

    localparam int DATA_W     = 8;
    localparam int NO_REG_CODE = 6;

endpackage

// File: rtl/ixbit_addr.sv
module ixbit_addr #(
    parameter int ADDR_W = 16,
    parameter int DISP_W = 8
) (
    input  logic [ADDR_W-1:0] base,
    input  logic [DISP_W-1:0] offs,
    output logic [ADDR_W-1:0] ea
);
    localparam int EXT_W = ADDR_W - DISP_W;

    logic [ADDR_W-1:0] offs_ext;

    // sign-extend the offset, then add; the carry out is dropped (modulo wrap)
    assign offs_ext = {{EXT_W{offs[DISP_W-1]}}, offs};
    assign ea       = base + offs_ext;
endmodule

// File: rtl/ixbit_alu.sv
module ixbit_alu
    import ixbit_pkg::*;
(
    input  logic [7:0] opc,
    input  logic [7:0] din,
    input  logic [7:0] fin,
    input  logic [7:0] ea_hi,
    output logic [7:0] res,
    output logic [7:0] fout
);
    logic [2:0] sel;
    cls_t       cls;
    logic [7:0] mask;
    logic       co;
    logic       tbit;

    assign sel  = opc[5:3];
    assign cls  = cls_t'(opc[7:6]);
    assign mask = 8'd1 << sel;
    assign tbit = |(din & mask);

    always_comb begin
        res  = din;
        fout = fin;
        co   = 1'b0;
        unique case (cls)
            CL_SHIFT: begin
                unique case (sel)
                    3'd0: begin co = din[7]; res = {din[6:0], din[7]}; end
                    3'd1: begin co = din[0]; res = {din[0], din[7:1]}; end
                    3'd2: begin co = din[7]; res = {din[6:0], fin[0]}; end
                    3'd3: begin co = din[0]; res = {fin[0], din[7:1]}; end
                    3'd4: begin co = din[7]; res = {din[6:0], 1'b0}; end
                    3'd5: begin co = din[0]; res = {din[7], din[7:1]}; end
                    3'd6: begin co = din[7]; res = {din[6:0], 1'b1}; end
                    default: begin co = din[0]; res = {1'b0, din[7:1]}; end
                endcase
                fout = {res[7], (res == 8'h00), res[5], 1'b0,
                        res[3], ~^res, 1'b0, co};
            end
            CL_TEST: begin
                res  = din;
                fout = {(sel == 3'd7) & tbit, ~tbit, ea_hi[5], 1'b1,
                        ea_hi[3], ~tbit, 1'b0, fin[0]};
            end
            CL_CLR: res = din & ~mask;
            default: res = din | mask;
        endcase
    end
endmodule

// File: rtl/ixbit_unit.sv
module ixbit_unit
    import ixbit_pkg::*;
#(
    parameter int ADDR_W   = 16,
    parameter int DISP_W   = 8,
    parameter int CYC_W    = 5,
    parameter int TEST_CYC = 20,
    parameter int RMW_CYC  = 23
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [ADDR_W-1:0] idx_base,
    input  logic [DISP_W-1:0] disp,
    input  logic [7:0]        opcode,
    input  logic [7:0]        flags_in,
    output logic              busy,
    output logic              done,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_rd,
    output logic              mem_wr,
    output logic [7:0]        mem_wdata,
    input  logic [7:0]        mem_rdata,
    output logic              reg_we,
    output logic [2:0]        reg_sel,
    output logic [7:0]        reg_wdata,
    output logic [7:0]        flags_out,
    output logic [ADDR_W-1:0] mem_ptr,
    output logic [CYC_W-1:0]  cycles,
    output logic              fetch_adj
);
    localparam int HI_LSB = ADDR_W - 8;

    state_t            state_q, state_d;
    logic [7:0]        op_q;
    logic [7:0]        fl_in_q;
    logic [ADDR_W-1:0] ea_q;
    logic [7:0]        res_q;
    logic [7:0]        fl_q;
    logic [CYC_W-1:0]  cyc_q;

    logic [ADDR_W-1:0] ea_now;
    logic [7:0]        alu_res;
    logic [7:0]        alu_fl;
    logic              is_test;
    logic              accept;

    ixbit_addr #(.ADDR_W(ADDR_W), .DISP_W(DISP_W)) addr_i (
        .base (idx_base),
        .offs (disp),
        .ea   (ea_now)
    );

    ixbit_alu alu_i (
        .opc   (op_q),
        .din   (mem_rdata),
        .fin   (fl_in_q),
        .ea_hi (ea_q[ADDR_W-1:HI_LSB]),
        .res   (alu_res),
        .fout  (alu_fl)
    );

    assign is_test = (cls_t'(op_q[7:6]) == CL_TEST);
    assign accept  = (state_q == ST_IDLE) && start;

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (start) state_d = ST_READ;
            ST_READ:  state_d = ST_EXEC;
            ST_EXEC:  state_d = is_test ? ST_FIN : ST_WRITE;
            ST_WRITE: state_d = ST_FIN;
            ST_FIN:   state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // datapath registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            op_q    <= '0;
            fl_in_q <= '0;
            ea_q    <= '0;
            res_q   <= '0;
            fl_q    <= '0;
            cyc_q   <= '0;
        end else begin
            if (accept) begin
                op_q    <= opcode;
                fl_in_q <= flags_in;
                ea_q    <= ea_now;
                cyc_q   <= (cls_t'(opcode[7:6]) == CL_TEST) ?
                           CYC_W'(TEST_CYC) : CYC_W'(RMW_CYC);
            end
            if (state_q == ST_EXEC) begin
                res_q <= alu_res;
                fl_q  <= alu_fl;
            end
        end
    end

    // outputs decoded from the state
    always_comb begin
        busy      = (state_q != ST_IDLE);
        mem_rd    = 1'b0;
        mem_wr    = 1'b0;
        reg_we    = 1'b0;
        done      = 1'b0;
        fetch_adj = 1'b0;
        unique case (state_q)
            ST_IDLE, ST_EXEC: ;
            ST_READ:  mem_rd = 1'b1;
            ST_WRITE: begin
                mem_wr = 1'b1;
                reg_we = (op_q[2:0] != 3'(NO_REG_CODE));
            end
            ST_FIN: begin
                done      = 1'b1;
                fetch_adj = 1'b1;
            end
            default: ;
        endcase
    end

    assign mem_addr  = ea_q;
    assign mem_ptr   = ea_q;
    assign mem_wdata = res_q;
    assign reg_wdata = res_q;
    assign reg_sel   = op_q[2:0];
    assign flags_out = fl_q;
    assign cycles    = cyc_q;
endmodule

// File: rtl/ixbit_unit_chk.sv
module ixbit_unit_chk #(
    parameter int ADDR_W   = 16,
    parameter int CYC_W    = 5,
    parameter int TEST_CYC = 20,
    parameter int RMW_CYC  = 23
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic              busy,
    input logic              done,
    input logic              mem_rd,
    input logic              mem_wr,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [ADDR_W-1:0] mem_ptr,
    input logic              reg_we,
    input logic [CYC_W-1:0]  cycles,
    input logic              fetch_adj
);
    // R1
    read_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> (mem_rd && mem_addr == mem_ptr));

    // R9
    strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_rd && mem_wr));

    // R9
    write_after_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr |-> $past(mem_rd, 2));

    // R9
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R7
    reg_with_mem_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reg_we |-> mem_wr);

    // R8
    cycle_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (cycles == CYC_W'(TEST_CYC) || cycles == CYC_W'(RMW_CYC)));

    // R10
    adj_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_adj |-> done);

    // R11
    busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done) |=> busy);
endmodule

bind ixbit_unit ixbit_unit_chk #(
    .ADDR_W   (ADDR_W),
    .CYC_W    (CYC_W),
    .TEST_CYC (TEST_CYC),
    .RMW_CYC  (RMW_CYC)
) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .busy      (busy),
    .done      (done),
    .mem_rd    (mem_rd),
    .mem_wr    (mem_wr),
    .mem_addr  (mem_addr),
    .mem_ptr   (mem_ptr),
    .reg_we    (reg_we),
    .cycles    (cycles),
    .fetch_adj (fetch_adj)
);

// File: tb/ixbit_unit_tb_top.sv
module ixbit_unit_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [15:0] idx_base = '0;
    logic [7:0]  disp = '0;
    logic [7:0]  opcode = '0;
    logic [7:0]  flags_in = '0;
    logic        busy, done, mem_rd, mem_wr, reg_we, fetch_adj;
    logic [15:0] mem_addr, mem_ptr;
    logic [7:0]  mem_wdata, mem_rdata, reg_wdata, flags_out;
    logic [2:0]  reg_sel;
    logic [4:0]  cycles;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    ixbit_unit dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .idx_base(idx_base),
        .disp(disp), .opcode(opcode), .flags_in(flags_in), .busy(busy),
        .done(done), .mem_addr(mem_addr), .mem_rd(mem_rd), .mem_wr(mem_wr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .reg_we(reg_we),
        .reg_sel(reg_sel), .reg_wdata(reg_wdata), .flags_out(flags_out),
        .mem_ptr(mem_ptr), .cycles(cycles), .fetch_adj(fetch_adj)
    );

    // memory model and monitors
    logic [7:0] mem [256];
    logic       pre_we = 1'b0;
    logic [7:0] pre_addr = '0, pre_data = '0;
    int rd_n = 0, wr_n = 0, rg_n = 0, adj_n = 0;
    logic [15:0] rd_cap, wr_cap;
    logic [7:0]  rg_data_cap;
    logic [2:0]  rg_sel_cap;

    always @(posedge clk) begin
        if (pre_we) mem[pre_addr] <= pre_data;
        if (mem_rd) begin
            mem_rdata <= mem[mem_addr[7:0]];
            rd_cap    <= mem_addr;
            rd_n      <= rd_n + 1;
        end
        if (mem_wr) begin
            mem[mem_addr[7:0]] <= mem_wdata;
            wr_cap <= mem_addr;
            wr_n   <= wr_n + 1;
        end
        if (reg_we) begin
            rg_n        <= rg_n + 1;
            rg_sel_cap  <= reg_sel;
            rg_data_cap <= reg_wdata;
        end
        if (fetch_adj) adj_n <= adj_n + 1;
    end

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic bit even_par(input logic [7:0] v);
        int n = 0;
        for (int i = 0; i < 8; i++) n += v[i];
        return (n % 2) == 0;
    endfunction

    // expected {result, flags}
    function automatic logic [15:0] model(input logic [7:0] op, input logic [7:0] v,
                                          input logic [7:0] f, input logic [7:0] hi);
        int kind = op / 64;
        int n    = (op / 8) % 8;
        int r;
        int c;
        logic [7:0] rr, ff;
        if (kind == 0) begin
            if (n % 2 == 0) begin
                int fill;
                case (n)
                    0: fill = v / 128;
                    2: fill = f % 2;
                    4: fill = 0;
                    default: fill = 1;
                endcase
                r = ((v * 2) % 256) + fill;
                c = v / 128;
            end else begin
                int top;
                case (n)
                    1: top = v % 2;
                    3: top = f % 2;
                    5: top = v / 128;
                    default: top = 0;
                endcase
                r = v / 2 + top * 128;
                c = v % 2;
            end
            rr = 8'(r);
            ff = 8'h00;
            ff[7] = rr[7]; ff[6] = (r == 0); ff[5] = rr[5]; ff[3] = rr[3];
            ff[2] = even_par(rr); ff[0] = 1'(c);
        end else if (kind == 1) begin
            int b = (v >> n) % 2;
            rr = v;
            ff = 8'h10;
            ff[7] = (n == 7) && (b == 1);
            ff[6] = (b == 0); ff[2] = (b == 0);
            ff[5] = hi[5]; ff[3] = hi[3]; ff[0] = f[0];
        end else if (kind == 2) begin
            rr = v & ~(8'd1 << n);
            ff = f;
        end else begin
            rr = v | (8'd1 << n);
            ff = f;
        end
        return {rr, ff};
    endfunction

    task automatic run(input logic [7:0] op, input logic [15:0] ib,
                       input logic [7:0] d, input logic [7:0] f, input logic [7:0] v);
        int sd = (d >= 128) ? int'(d) - 256 : int'(d);
        logic [15:0] ea = 16'((int'(ib) + sd + 65536) % 65536);
        logic [15:0] exp = model(op, v, f, ea[15:8]);
        bit test = (op / 64 == 1);
        int rd0, wr0, rg0, adj0, n;
        @(negedge clk);
        pre_we = 1'b1; pre_addr = ea[7:0]; pre_data = v;
        @(negedge clk);
        pre_we = 1'b0;
        rd0 = rd_n; wr0 = wr_n; rg0 = rg_n; adj0 = adj_n;
        start = 1'b1; opcode = op; idx_base = ib; disp = d; flags_in = f;
        n = 0;
        while (n < 10) begin
            @(posedge clk);
            n++;
            @(negedge clk);
            if (n == 1) begin
                chk("R1", "read strobe", mem_rd, 1);
                chk("R1", "address", mem_addr, ea);
                // R11: second start with altered operands while busy
                opcode = ~op; idx_base = ib ^ 16'h5555; disp = d ^ 8'h3C; flags_in = ~f;
            end else begin
                start = 1'b0;
            end
            if (done) break;
        end
        chk("R9", "done latency", n, test ? 3 : 4);
        chk("R10", "fetch adjust with done", fetch_adj, 1);
        chk("R1", "memory pointer", mem_ptr, ea);
        chk("R1", "read address", rd_cap, ea);
        chk("R8", "cycle count", cycles, test ? 20 : 23);
        chk("R4", "flags", flags_out, exp[7:0]);
        if (test) begin
            chk("R6", "no memory write", wr_n - wr0, 0);
            chk("R6", "no register write", rg_n - rg0, 0);
            chk("R6", "memory unchanged", mem[ea[7:0]], v);
        end else begin
            chk("R7", "one memory write", wr_n - wr0, 1);
            chk("R7", "write address", wr_cap, ea);
            chk("R3", "memory result", mem[ea[7:0]], exp[15:8]);
            if (op % 8 == 6) begin
                chk("R7", "no register copy for code 6", rg_n - rg0, 0);
            end else begin
                chk("R7", "one register copy", rg_n - rg0, 1);
                chk("R7", "register code", rg_sel_cap, op % 8);
                chk("R7", "register data", rg_data_cap, exp[15:8]);
            end
        end
        @(negedge clk);
        chk("R9", "done one cycle", done, 0);
        chk("R11", "idle after instruction", busy, 0);
        chk("R10", "one adjust pulse", adj_n - adj0, 1);
        chk("R9", "one read", rd_n - rd0, 1);
    endtask

    task automatic sweep();
        logic [7:0] vals [8] = '{8'h00, 8'hFF, 8'h80, 8'h01, 8'hA5, 8'h5A, 8'h3C, 8'h81};
        for (int op = 0; op < 256; op++) begin
            for (int p = 0; p < 8; p++) begin
                logic [15:0] ib;
                logic [7:0]  d;
                if (p == 6) begin ib = 16'hFFF0; d = 8'h20; end       // wraps past top
                else if (p == 7) begin ib = 16'h0005; d = 8'hF0; end  // wraps below zero
                else begin
                    ib = 16'((p + 1) * 16'h1234) ^ 16'(op << 4);
                    d  = 8'((op * 37 + p * 91) % 256);
                end
                run(8'(op), ib, d, (p % 2 == 1) ? 8'hFF : 8'h00, vals[p]);
            end
        end
    endtask

    initial begin
        bit timeout = 1'b0;
        for (int i = 0; i < 256; i++) mem[i] = 8'h00;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R12 reset state
        chk("R12", "busy", busy, 0);
        chk("R12", "done", done, 0);
        chk("R12", "strobes", {mem_rd, mem_wr, reg_we, fetch_adj}, 0);
        chk("R12", "mem_ptr", mem_ptr, 0);
        chk("R12", "cycles", cycles, 0);
        chk("R12", "flags_out", flags_out, 0);
        rst_n = 1'b1;
        fork
            begin
                // R2 R3 R4 R5 R6 R7 R8 R9 R10 R11 across all opcodes
                sweep();
            end
            begin
                repeat (190000) @(posedge clk);
                timeout = 1'b1;
            end
        join_any
        disable fork;
        if (timeout) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
        end
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule